// File: doc/BRIEF.md
# Memory Port Self-Test Engine

This block exercises a single-ported 16-bit memory through a fixed, ordered series of writes and reads, and reports whether the memory and its wiring behave. A one-cycle start pulse launches a run. The engine then walks a single set bit across the data lines at address 0. Next it probes every power-of-two address offset inside the selected span with the patterns 0xAAAA and 0x5555 to expose address lines that are stuck or shorted together. Finally it sweeps the whole span three times with an incrementing count, its bitwise inverse, and zero.

The engine drives a plain synchronous request port. It holds a request with its address, direction and write data until the memory raises ready. The run stops at the first read that differs from its expected value. A report then holds the phase in which the failure happened, the address that identifies it, and the value that was expected. A clean run leaves every word of the span cleared and sets the pass flag.

Top module: `memtest_engine`

## Requirements
- R1: A start pulse is taken only while the engine is idle or finished. Taking it sets busy on the next cycle and clears done, pass, fail_phase, fail_addr and fail_data. A start pulse seen while busy has no effect on the run.
- R2: An access completes on a cycle in which mem_req and mem_rdy are both high. Read data is taken from mem_rdata in that same cycle. While mem_rdy is low, mem_req, mem_we, mem_addr and mem_wdata hold their values. The next access, if any, is presented on the following cycle.
- R3: The data phase writes, and then reads back, each one-hot pattern from 0x0001 up to 0x8000 at address 0. On a mismatch it stops with fail_phase 0, fail_addr 0, and fail_data equal to the pattern.
- R4: The stuck-high check writes 0xAAAA at every power-of-two offset in the span and 0x5555 at offset 0. It then reads each power-of-two offset, lowest first. On a read that differs from 0xAAAA it stops with fail_phase 1, fail_addr equal to that offset, and fail_data 0xAAAA.
- R5: The stuck-low/short check takes each power-of-two test offset in turn. It writes 0x5555 there, then reads offset 0 and every other power-of-two offset for 0xAAAA, and finally restores the test offset to 0xAAAA. On a mismatch it stops with fail_phase 2, fail_addr equal to the test offset, and fail_data 0xAAAA.
- R6: The device phase fills word k with 7+k. It then verifies each word and writes back its bitwise inverse. A last pass verifies the inverse and writes 0. On a mismatch it stops with fail_phase 3, fail_addr equal to the word, and fail_data equal to the expected value. After a clean run every word of the span holds 0.
- R7: The span is 2^n words from address 0, where n is span_log2 sampled when start is taken. A value of 0 is treated as 1, and a value above ADDR_W is treated as ADDR_W. No access leaves the span.
- R8: With mem_rdy held high, one access completes per cycle. A clean run of span n completes exactly 32 + n*n + 4n + 2 + 5*2^n accesses.
- R9: done rises at the edge on which the final access, or the first failing read, completes. pass is high only on a clean run. After done, no request is made, and the report holds until the next start.
- R10: After reset, mem_req, busy, done, pass, fail_phase, fail_addr and fail_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| span_log2 | input | SPAN_W | Log2 of the tested span in words |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no mismatch |
| fail_phase | output | 2 | 0 data, 1 address stuck-high, 2 address stuck-low/short, 3 device |
| fail_addr | output | ADDR_W | Address identifying the failure |
| fail_data | output | DATA_W | Expected value at the failure |

## Verification
The completion of the last clear write and the arrival of a new start pulse can land on the same clock edge. The bench provokes this by counting handshakes while ready is held high. It pulses start exactly while the final access is being presented. The run must still finish with done and pass set and the exact access total, and the engine must stay finished, not restarted, because start was seen while busy. A later pulse given to the finished engine must restart it and clear the report.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_DB_WR,
        S_DB_RD,
        S_AF_WR,
        S_AH_W0,
        S_AH_RD,
        S_AH_RS,
        S_AL_WT,
        S_AL_R0,
        S_AL_RP,
        S_AL_RST,
        S_DV_FILL,
        S_DV_CHK,
        S_DV_INV,
        S_DV_VRD,
        S_DV_CLR,
        S_DONE
    } step_e;

    typedef enum logic [1:0] {
        PH_DATA    = 2'd0,
        PH_ADDR_HI = 2'd1,
        PH_ADDR_LO = 2'd2,
        PH_CELL    = 2'd3
    } phase_e;

endpackage

// File: rtl/mbist_span.sv
module mbist_span #(
    parameter int ADDR_W = 16,
    parameter int SPAN_W = $clog2(ADDR_W + 1)
) (
    input  logic [SPAN_W-1:0] span_in,
    output logic [ADDR_W-1:0] mask
);
    localparam logic [SPAN_W-1:0] SPAN_MAX = SPAN_W'(ADDR_W);

    logic [SPAN_W-1:0] span_eff;

    // clamp the requested span into 1..ADDR_W
    always_comb begin
        if (span_in == '0)
            span_eff = SPAN_W'(1);
        else if (span_in > SPAN_MAX)
            span_eff = SPAN_MAX;
        else
            span_eff = span_in;
        mask = ~({ADDR_W{1'b1}} << span_eff);
    end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] mask_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              launch,
    output logic              ev_pass,
    output logic              ev_fail,
    output phase_e            ev_phase,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);
    localparam logic [DATA_W-1:0] PAT_A = {(DATA_W/2){2'b10}};
    localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;
    localparam logic [DATA_W-1:0] SEED  = DATA_W'(7);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

    typedef struct packed {
        step_e             st;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] prb;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] pat;
        logic [DATA_W-1:0] val;
    } ctl_t;

    ctl_t q, d;

    logic [DATA_W-1:0] acc_exp;
    logic              hs;
    logic              miss;

    function automatic logic [ADDR_W-1:0] probe_after(
        input logic [ADDR_W-1:0] cur, input logic [ADDR_W-1:0] tst);
        logic [ADDR_W-1:0] p;
        p = cur << 1;
        if (p == tst) p = p << 1;
        return p;
    endfunction

    function automatic logic [ADDR_W-1:0] probe_first(input logic [ADDR_W-1:0] tst);
        return (tst == A_ONE) ? (A_ONE << 1) : A_ONE;
    endfunction

    // access presented by the current step
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        acc_exp   = '0;
        unique case (q.st)
            S_DB_WR:   begin mem_we = 1'b1; mem_wdata = q.pat; end
            S_DB_RD:   acc_exp = q.pat;
            S_AF_WR:   begin mem_we = 1'b1; mem_addr = q.off; mem_wdata = PAT_A; end
            S_AH_W0:   begin mem_we = 1'b1; mem_wdata = PAT_B; end
            S_AH_RD:   begin mem_addr = q.off; acc_exp = PAT_A; end
            S_AH_RS:   begin mem_we = 1'b1; mem_wdata = PAT_A; end
            S_AL_WT:   begin mem_we = 1'b1; mem_addr = q.off; mem_wdata = PAT_B; end
            S_AL_R0:   acc_exp = PAT_A;
            S_AL_RP:   begin mem_addr = q.prb; acc_exp = PAT_A; end
            S_AL_RST:  begin mem_we = 1'b1; mem_addr = q.off; mem_wdata = PAT_A; end
            S_DV_FILL: begin mem_we = 1'b1; mem_addr = q.adr; mem_wdata = q.val; end
            S_DV_CHK:  begin mem_addr = q.adr; acc_exp = q.val; end
            S_DV_INV:  begin mem_we = 1'b1; mem_addr = q.adr; mem_wdata = ~q.val; end
            S_DV_VRD:  begin mem_addr = q.adr; acc_exp = ~q.val; end
            S_DV_CLR:  begin mem_we = 1'b1; mem_addr = q.adr; end
            default:   mem_req = 1'b0;
        endcase
        busy = mem_req;
        hs   = mem_req && mem_rdy;
        miss = !mem_we && (mem_rdata != acc_exp);
    end

    // next-state computation
    always_comb begin
        logic [ADDR_W-1:0] nx;
        d        = q;
        launch   = 1'b0;
        ev_pass  = 1'b0;
        ev_fail  = 1'b0;
        ev_phase = PH_DATA;
        ev_addr  = '0;
        ev_data  = acc_exp;
        nx       = '0;
        unique case (q.st)
            S_IDLE, S_DONE: begin
                if (start) begin
                    launch = 1'b1;
                    d.st   = S_DB_WR;
                    d.pat  = DATA_W'(1);
                    d.mask = mask_in;
                end
            end
            S_DB_WR: if (hs) d.st = S_DB_RD;
            S_DB_RD: if (hs) begin
                if (miss) begin
                    ev_fail = 1'b1;
                    d.st    = S_DONE;
                end else if (q.pat[DATA_W-1]) begin
                    d.st  = S_AF_WR;
                    d.off = A_ONE;
                end else begin
                    d.pat = q.pat << 1;
                    d.st  = S_DB_WR;
                end
            end
            S_AF_WR: if (hs) begin
                nx = q.off << 1;
                if ((nx & q.mask) != '0) d.off = nx;
                else                     d.st  = S_AH_W0;
            end
            S_AH_W0: if (hs) begin
                d.st  = S_AH_RD;
                d.off = A_ONE;
            end
            S_AH_RD: if (hs) begin
                nx = q.off << 1;
                if (miss) begin
                    ev_fail  = 1'b1;
                    ev_phase = PH_ADDR_HI;
                    ev_addr  = q.off;
                    d.st     = S_DONE;
                end else if ((nx & q.mask) != '0) begin
                    d.off = nx;
                end else begin
                    d.st = S_AH_RS;
                end
            end
            S_AH_RS: if (hs) begin
                d.st  = S_AL_WT;
                d.off = A_ONE;
            end
            S_AL_WT: if (hs) d.st = S_AL_R0;
            S_AL_R0, S_AL_RP: if (hs) begin
                nx = (q.st == S_AL_R0) ? probe_first(q.off) : probe_after(q.prb, q.off);
                if (miss) begin
                    ev_fail  = 1'b1;
                    ev_phase = PH_ADDR_LO;
                    ev_addr  = q.off;
                    d.st     = S_DONE;
                end else if ((nx & q.mask) != '0) begin
                    d.prb = nx;
                    d.st  = S_AL_RP;
                end else begin
                    d.st = S_AL_RST;
                end
            end
            S_AL_RST: if (hs) begin
                nx = q.off << 1;
                if ((nx & q.mask) != '0) begin
                    d.off = nx;
                    d.st  = S_AL_WT;
                end else begin
                    d.st  = S_DV_FILL;
                    d.adr = '0;
                    d.val = SEED;
                end
            end
            S_DV_FILL: if (hs) begin
                if (q.adr == q.mask) begin
                    d.adr = '0;
                    d.val = SEED;
                    d.st  = S_DV_CHK;
                end else begin
                    d.adr = q.adr + A_ONE;
                    d.val = q.val + DATA_W'(1);
                end
            end
            S_DV_CHK, S_DV_VRD: if (hs) begin
                if (miss) begin
                    ev_fail  = 1'b1;
                    ev_phase = PH_CELL;
                    ev_addr  = q.adr;
                    d.st     = S_DONE;
                end else begin
                    d.st = (q.st == S_DV_CHK) ? S_DV_INV : S_DV_CLR;
                end
            end
            S_DV_INV: if (hs) begin
                if (q.adr == q.mask) begin
                    d.adr = '0;
                    d.val = SEED;
                    d.st  = S_DV_VRD;
                end else begin
                    d.adr = q.adr + A_ONE;
                    d.val = q.val + DATA_W'(1);
                    d.st  = S_DV_CHK;
                end
            end
            S_DV_CLR: if (hs) begin
                if (q.adr == q.mask) begin
                    ev_pass = 1'b1;
                    d.st    = S_DONE;
                end else begin
                    d.adr = q.adr + A_ONE;
                    d.val = q.val + DATA_W'(1);
                    d.st  = S_DV_VRD;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // R2: a pending request and its fields do not move while ready is low
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    // R3: the data phase only ever writes a single set bit
    p_walk_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DB_WR) |-> ($countones(mem_wdata) == 1 && mem_addr == '0));

    // R7: every access stays inside the latched span
    p_in_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & ~q.mask) == '0));

endmodule

// File: rtl/mbist_report.sv
module mbist_report
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ev_pass,
    input  logic              ev_fail,
    input  phase_e            ev_phase,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    output logic              done,
    output logic              pass,
    output logic [1:0]        fail_phase,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data
);
    typedef struct packed {
        logic              done;
        logic              pass;
        logic [1:0]        phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rep_t;

    rep_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (ev_fail) begin
            d.done  = 1'b1;
            d.pass  = 1'b0;
            d.phase = ev_phase;
            d.addr  = ev_addr;
            d.data  = ev_data;
        end else if (ev_pass) begin
            d.done = 1'b1;
            d.pass = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done       = q.done;
    assign pass       = q.pass;
    assign fail_phase = q.phase;
    assign fail_addr  = q.addr;
    assign fail_data  = q.data;

    // R9: pass is only ever reported on a finished run
    p_pass_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SPAN_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SPAN_W-1:0] span_log2,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [1:0]        fail_phase,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data
);
    logic [ADDR_W-1:0] span_mask;
    logic              launch;
    logic              ev_pass;
    logic              ev_fail;
    phase_e            ev_phase;
    logic [ADDR_W-1:0] ev_addr;
    logic [DATA_W-1:0] ev_data;

    mbist_span #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_span (
        .span_in (span_log2),
        .mask    (span_mask)
    );

    mbist_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mask_in   (span_mask),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy),
        .busy      (busy),
        .launch    (launch),
        .ev_pass   (ev_pass),
        .ev_fail   (ev_fail),
        .ev_phase  (ev_phase),
        .ev_addr   (ev_addr),
        .ev_data   (ev_data)
    );

    mbist_report #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (launch),
        .ev_pass    (ev_pass),
        .ev_fail    (ev_fail),
        .ev_phase   (ev_phase),
        .ev_addr    (ev_addr),
        .ev_data    (ev_data),
        .done       (done),
        .pass       (pass),
        .fail_phase (fail_phase),
        .fail_addr  (fail_addr),
        .fail_data  (fail_data)
    );

    // R9: a finished engine issues no request
    p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R9: done rises only on the edge that completes an access
    p_done_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_req && mem_rdy));

    // R1: a run begins with a cleared report
    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done && !pass && fail_addr == '0);

endmodule

// File: tb/sim_memtest_engine.sv
`timescale 1ns/1ps
module sim_memtest_engine;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int SW = $clog2(AW + 1);
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] span_log2 = '0;
    logic          mem_req, mem_we, mem_rdy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          busy, done, pass;
    logic [1:0]    fail_phase;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_data;

    int checks = 0;
    int errors = 0;
    int fault  = 0;
    bit stall  = 1'b0;
    int hs_cnt = 0;
    logic [7:0] lfsr = 8'h5A;
    logic [DW-1:0] mem [WORDS];

    always #4 clk = ~clk;

    memtest_engine #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .span_log2(span_log2),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .busy(busy), .done(done), .pass(pass), .fail_phase(fail_phase),
        .fail_addr(fail_addr), .fail_data(fail_data)
    );

    // fault model: 1 data bit5 low, 2 addr bit2 high, 3 addr bits 2/3 shorted,
    // 4 word 9 bit0 high, 5 word 9 bit0 low
    function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
        logic [AW-1:0] p;
        p = a;
        if (fault == 2) p[2] = 1'b1;
        if (fault == 3) begin p[2] = a[2] | a[3]; p[3] = a[2] | a[3]; end
        return p;
    endfunction

    always_comb begin
        mem_rdata = mem[phys(mem_addr)];
        if (fault == 1) mem_rdata[5] = 1'b0;
        if (fault == 4 && phys(mem_addr) == AW'(9)) mem_rdata[0] = 1'b1;
        if (fault == 5 && phys(mem_addr) == AW'(9)) mem_rdata[0] = 1'b0;
    end

    assign mem_rdy = stall ? lfsr[0] : 1'b1;

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rst_n && mem_req && mem_rdy) begin
            hs_cnt <= hs_cnt + 1;
            if (mem_we) mem[phys(mem_addr)] <= mem_wdata;
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int total(input int n);
        return 2 * DW + n * n + 4 * n + 2 + 5 * (1 << n);
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    endtask

    task automatic run(input int span, input int flt, input bit stl, output int used);
        int base;
        fault = flt;
        stall = stl;
        span_log2 = SW'(span);
        base = hs_cnt;
        pulse_start();
        wait_done();
        used = hs_cnt - base;
    endtask

    task automatic t_reset();
        chk("R10", "req", 32'(mem_req), 0);
        chk("R10", "busy", 32'(busy), 0);
        chk("R10", "done/pass", {30'd0, done, pass}, 0);
        chk("R10", "fail fields", {fail_phase, 8'(fail_addr), fail_data}, 0);
    endtask

    task automatic t_clean(input int span, input int n, input bit stl, input string req);
        int used;
        run(span, 0, stl, used);
        chk(req, "done", 32'(done), 1);
        chk(req, "pass", 32'(pass), 1);
        chk("R8", "access count", used, total(n));
        for (int i = 0; i < (1 << n); i++)
            chk("R6", "word cleared", 32'(mem[i]), 0);
    endtask

    task automatic t_fault(input int flt, input string req, input logic [1:0] ph,
                           input int adr, input logic [DW-1:0] dat);
        int snap;
        int used;
        run(4, flt, 1'b1, used);
        chk(req, "done", 32'(done), 1);
        chk(req, "pass", 32'(pass), 0);
        chk(req, "phase", 32'(fail_phase), 32'(ph));
        chk(req, "addr", 32'(fail_addr), adr);
        chk(req, "data", 32'(fail_data), 32'(dat));
        snap = hs_cnt;
        repeat (6) @(negedge clk);
        chk("R9", "no access after fail", hs_cnt - snap, 0);
        chk("R9", "report held", {pass, fail_phase, 8'(fail_addr)}, {1'b0, ph, 8'(adr)});
    endtask

    task automatic t_restart_clears();
        fault = 0;
        stall = 1'b0;
        span_log2 = SW'(2);
        pulse_start();
        chk("R1", "busy after start", 32'(busy), 1);
        chk("R1", "report cleared", {done, pass, fail_phase, 8'(fail_addr), fail_data}, 0);
        wait_done();
        chk("R1", "restart passes", 32'(pass), 1);
    endtask

    task automatic t_start_ignored_mid();
        int base;
        fault = 0;
        stall = 1'b1;
        span_log2 = SW'(3);
        base = hs_cnt;
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        wait_done();
        chk("R1", "mid-run start ignored count", hs_cnt - base, total(3));
        chk("R1", "mid-run start ignored pass", 32'(pass), 1);
    endtask

    task automatic t_start_on_last();
        int base;
        fault = 0;
        stall = 1'b0;
        span_log2 = SW'(3);
        base = hs_cnt;
        pulse_start();
        while (hs_cnt - base != total(3) - 1) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R9", "done on last edge", {30'd0, done, pass}, 3);
        chk("R8", "one access per cycle total", hs_cnt - base, total(3));
        @(negedge clk);
        chk("R1", "start on last edge ignored", {busy, done}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean(4, 4, 1'b0, "R2");
        t_clean(6, 6, 1'b1, "R2");
        t_clean(0, 1, 1'b1, "R7");
        t_clean(7, 6, 1'b0, "R7");
        t_fault(1, "R3", 2'd0, 0, 16'h0020);
        t_restart_clears();
        t_fault(2, "R4", 2'd1, 4, 16'hAAAA);
        t_fault(3, "R5", 2'd2, 4, 16'hAAAA);
        t_fault(4, "R6", 2'd3, 9, 16'h0010);
        t_fault(5, "R6", 2'd3, 9, 16'hFFEF);
        t_start_ignored_mid();
        t_start_on_last();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule